// File: doc/BRIEF.md
# Secure-Aware Interrupt Router

The router gathers a bank of edge-signalled interrupt sources and delivers each one to up to four processors, as either a normal (IRQ) or a fast (FIQ) request. Every source owns one routing word. For each processor, that word holds a small slice with the following fields:

- a two-bit level: masked, low, high or non-maskable;
- a request-type bit;
- a secure-ownership bit.

A rising edge on a source latches its pending bit. A processor's IRQ or FIQ line is high while any pending source is routed to it with the matching type and a level other than masked.

Software reaches the block over a plain register bus. Every access completes in the cycle it is presented: there is no back-pressure, and read data is a combinational function of the address and the security attribute. Each writable register answers at three addresses:

- +0 replaces the register contents.
- +4 sets the written 1-bits.
- +8 clears the written 1-bits.

The bus carries a secure attribute. Non-secure masters cannot observe or clear pending bits of sources that are secure-owned, and cannot rewrite a routing slice that is marked secure. A lock bit in the control register makes the control register itself writable only by secure masters. The control register also holds an event-gating bit, which stops capture of new edges, and a self-clearing soft-reset bit.

Top module: `secure_irq_router`

## Requirements
- R1: After rst_n is released, all routing words, pending bits and control bits are 0, every irq_out and fiq_out bit is 0, and every register reads 0.
- R2: A 0-to-1 change on irq_in[i], seen at a clock edge, sets pending bit i at that edge. A source held high after its pending bit is cleared is not captured again until it falls and rises again.
- R3: The routing word holds slice c in bits [4c+3:4c]. Within a slice, [3:2] is the level (0 masked, 1 low, 2 high, 3 non-maskable), [1] is the type (0 IRQ, 1 FIQ) and [0] is the secure flag. irq_out[c] (fiq_out[c]) is high exactly when some pending source has a non-zero level in slice c and type 0 (type 1).
- R4: The routing word of source i sits at 0x20 + 0x10*i. A write at +0 replaces it, +4 ORs in the write data, +8 clears the written 1-bits, and a read at any of the three addresses returns it.
- R5: The pending register reads at 0x10 (and 0x14, 0x18) with bit i for source i. Writing 1-bits at 0x18 clears those pending bits. Writes at 0x10 and 0x14 change nothing.
- R6: If a rising edge on a source and a bus clear of that same source's pending bit fall in the same cycle, the bit ends set.
- R7: A source is secure-owned when any of its slices has bit 0 set. A non-secure read of the pending register returns 0 in that bit position, and a non-secure clear of that bit has no effect.
- R8: A non-secure write leaves unchanged every slice whose secure bit is currently 1. Other slices in the same write are updated, and a secure master can change any slice.
- R9: The control register is at 0x00 with aliases at +4 and +8: bit 7 gates events, bit 6 is soft reset, bit 5 is the lock, and the other bits read 0. While the lock is 1, a non-secure control write changes nothing.
- R10: While the gating bit is 1, rising edges are not captured and are lost. Pending bits already set, and the outputs they drive, are kept.
- R11: The cycle after soft reset is written to 1, every routing word and pending bit is 0 and soft reset reads 0. Gating and lock keep their values, and routing or pending writes made in that cycle are dropped.
- R12: Addresses outside the map, and offsets other than 0, 4 and 8 within a 16-byte block, read 0 and accept no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_secure | input | 1 | 1 when the current master is secure |
| bus_rdata | output | DATA_W | Read data for bus_addr and bus_secure, combinational |
| irq_in | input | NUM_SRC | Interrupt sources, captured on rising edges |
| irq_out | output | NUM_CPU | Normal interrupt request per processor |
| fiq_out | output | NUM_CPU | Fast interrupt request per processor |

## Verification
The hazard that matters is a source edge and a bus clear of the same pending bit landing in one cycle. The bench provokes it by raising the source in the very cycle that it writes the clear alias. It then judges the outcome by reading the pending register and watching the routed output, both of which must show the bit still set. A second collision is a soft reset arriving together with bus writes to routing words, where the writes must be lost. Random traffic mixes both collisions with lock and gating changes, and a behavioural model compared every cycle judges those cycles.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int SLICE_W  = 4;
  localparam int SEC_BIT  = 0;
  localparam int TYPE_BIT = 1;
  localparam int LVL_LSB  = 2;

  localparam int CTRL_GATE_BIT = 7;
  localparam int CTRL_SRST_BIT = 6;
  localparam int CTRL_LOCK_BIT = 5;

  localparam logic [3:0] OFS_WRITE = 4'h0;
  localparam logic [3:0] OFS_SET   = 4'h4;
  localparam logic [3:0] OFS_CLEAR = 4'h8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } reg_op_e;
endpackage

// File: rtl/sirq_bus_decode.sv
module sirq_bus_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_op_e           op,
  output logic              hit_ctrl,
  output logic              hit_status,
  output logic              hit_route,
  output logic [SRC_W-1:0]  route_idx
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] rel;
  logic             op_ok;
  logic             unused_rel_hi;

  assign blk = addr[ADDR_W-1:4];

  always_comb begin
    case (addr[3:0])
      OFS_WRITE: op = OP_WRITE;
      OFS_SET:   op = OP_SET;
      OFS_CLEAR: op = OP_CLEAR;
      default:   op = OP_NONE;
    endcase
  end

  assign op_ok      = (op != OP_NONE);
  assign hit_ctrl   = op_ok && (blk == '0);
  assign hit_status = op_ok && (blk == BLK_W'(1));
  assign hit_route  = op_ok && (blk >= BLK_W'(2)) && (blk < BLK_W'(2 + NUM_SRC));

  assign rel           = blk - BLK_W'(2);
  assign route_idx     = rel[SRC_W-1:0];
  assign unused_rel_hi = ^rel[BLK_W-1:SRC_W];
endmodule

// File: rtl/sirq_route_bank.sv
module sirq_route_bank
  import sirq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int ROUTE_W = NUM_CPU * SLICE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             soft_clr,
  input  logic                             wr_en,
  input  logic [SRC_W-1:0]                 wr_idx,
  input  reg_op_e                          op,
  input  logic [ROUTE_W-1:0]               wdata,
  input  logic                             secure,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0]  route
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic sel;
    assign sel = wr_en && (wr_idx == SRC_W'(s));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_slice
      logic [SLICE_W-1:0] slice_q;
      logic [SLICE_W-1:0] wbits;
      logic [SLICE_W-1:0] req;
      logic               guarded;

      assign wbits   = wdata[c*SLICE_W +: SLICE_W];
      assign guarded = slice_q[SEC_BIT] && !secure;

      always_comb begin
        case (op)
          OP_WRITE: req = wbits;
          OP_SET:   req = slice_q | wbits;
          OP_CLEAR: req = slice_q & ~wbits;
          default:  req = slice_q;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slice_q <= '0;
        end else if (soft_clr) begin
          slice_q <= '0;
        end else if (sel && !guarded) begin
          slice_q <= req;
        end
      end

      assign route[s][c*SLICE_W +: SLICE_W] = slice_q;
    end
  end
endmodule

// File: rtl/sirq_pending.sv
module sirq_pending #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               gate,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] capture;

  assign rise    = irq_in & ~prev_q;
  assign capture = gate ? '0 : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= irq_in;
    end
  end

  // A clear and a new edge on the same bit: the edge is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (soft_clr) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~clr_mask) | capture;
    end
  end
endmodule

// File: rtl/sirq_fanout.sv
module sirq_fanout
  import sirq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  localparam int ROUTE_W = NUM_CPU * SLICE_W
) (
  input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route,
  input  logic [NUM_SRC-1:0]              pending,
  output logic [NUM_CPU-1:0]              irq_out,
  output logic [NUM_CPU-1:0]              fiq_out
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] to_irq;
    logic [NUM_SRC-1:0] to_fiq;
    logic [NUM_SRC-1:0] sec_seen;
    logic               unused_sec;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [1:0] lvl;
      logic       is_fast;
      logic       live;
      assign lvl         = route[s][c*SLICE_W + LVL_LSB +: 2];
      assign is_fast     = route[s][c*SLICE_W + TYPE_BIT];
      assign live        = pending[s] && (lvl != 2'd0);
      assign to_irq[s]   = live && !is_fast;
      assign to_fiq[s]   = live && is_fast;
      assign sec_seen[s] = route[s][c*SLICE_W + SEC_BIT];
    end

    assign irq_out[c]  = |to_irq;
    assign fiq_out[c]  = |to_fiq;
    assign unused_sec  = ^sec_seen;
  end
endmodule

// File: rtl/secure_irq_router.sv
module secure_irq_router
  import sirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               bus_secure,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_CPU-1:0] irq_out,
  output logic [NUM_CPU-1:0] fiq_out
);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int ROUTE_W = NUM_CPU * SLICE_W;

  reg_op_e                         op;
  logic                            hit_ctrl;
  logic                            hit_status;
  logic                            hit_route;
  logic [SRC_W-1:0]                route_idx;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route;
  logic [NUM_SRC-1:0]              pend_q;
  logic [NUM_SRC-1:0]              secured;
  logic [NUM_SRC-1:0]              visible;
  logic [NUM_SRC-1:0]              clr_mask;
  logic                            gate_q;
  logic                            srst_q;
  logic                            lock_q;
  logic                            ctrl_we;
  logic [2:0]                      ctrl_cur;
  logic [2:0]                      ctrl_req;
  logic [2:0]                      ctrl_wbits;
  logic                            route_we;

  sirq_bus_decode #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC)
  ) u_decode (
    .addr      (bus_addr),
    .op        (op),
    .hit_ctrl  (hit_ctrl),
    .hit_status(hit_status),
    .hit_route (hit_route),
    .route_idx (route_idx)
  );

  assign route_we = bus_we && hit_route && !srst_q;

  sirq_route_bank #(
    .NUM_SRC(NUM_SRC),
    .NUM_CPU(NUM_CPU)
  ) u_routes (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(srst_q),
    .wr_en   (route_we),
    .wr_idx  (route_idx),
    .op      (op),
    .wdata   (bus_wdata[ROUTE_W-1:0]),
    .secure  (bus_secure),
    .route   (route)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_own
    logic [NUM_CPU-1:0] flags;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_flag
      assign flags[c] = route[s][c*SLICE_W + SEC_BIT];
    end
    assign secured[s] = |flags;
  end

  assign visible  = bus_secure ? pend_q : (pend_q & ~secured);
  assign clr_mask = (bus_we && hit_status && (op == OP_CLEAR))
                  ? (bus_wdata[NUM_SRC-1:0] & (bus_secure ? '1 : ~secured))
                  : '0;

  sirq_pending #(
    .NUM_SRC(NUM_SRC)
  ) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(srst_q),
    .gate    (gate_q),
    .irq_in  (irq_in),
    .clr_mask(clr_mask),
    .pending (pend_q)
  );

  sirq_fanout #(
    .NUM_SRC(NUM_SRC),
    .NUM_CPU(NUM_CPU)
  ) u_fanout (
    .route  (route),
    .pending(pend_q),
    .irq_out(irq_out),
    .fiq_out(fiq_out)
  );

  // Control register: gating, soft reset, lock.
  assign ctrl_cur   = {gate_q, srst_q, lock_q};
  assign ctrl_wbits = bus_wdata[CTRL_GATE_BIT:CTRL_LOCK_BIT];
  assign ctrl_we    = bus_we && hit_ctrl && (!lock_q || bus_secure);

  always_comb begin
    case (op)
      OP_WRITE: ctrl_req = ctrl_wbits;
      OP_SET:   ctrl_req = ctrl_cur | ctrl_wbits;
      OP_CLEAR: ctrl_req = ctrl_cur & ~ctrl_wbits;
      default:  ctrl_req = ctrl_cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      srst_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        gate_q <= ctrl_req[2];
        lock_q <= ctrl_req[0];
      end
      srst_q <= srst_q ? 1'b0 : (ctrl_we && ctrl_req[1]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CTRL_GATE_BIT:CTRL_LOCK_BIT] = ctrl_cur;
    end else if (hit_status) begin
      bus_rdata[NUM_SRC-1:0] = visible;
    end else if (hit_route) begin
      bus_rdata[ROUTE_W-1:0] = route[route_idx];
    end
  end
endmodule

// File: rtl/sirq_router_checker.sv
module sirq_router_checker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [NUM_CPU-1:0] irq_out,
  input logic [NUM_CPU-1:0] fiq_out,
  input logic [NUM_SRC-1:0] pending,
  input logic               gate,
  input logic               srst,
  input logic               lock,
  input logic               bus_we,
  input logic               bus_secure,
  input logic [ADDR_W-1:0]  bus_addr
);
  logic ctrl_access;
  assign ctrl_access = (bus_addr[ADDR_W-1:4] == '0) &&
                       ((bus_addr[3:0] == 4'h0) || (bus_addr[3:0] == 4'h4) ||
                        (bus_addr[3:0] == 4'h8));

  // R3: no pending source means no request line is up
  p_idle_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> ((irq_out == '0) && (fiq_out == '0)));

  // R2 and R6: every ungated rising edge lands in the pending register
  p_edge_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !srst) |=>
      ((($past(irq_in) & ~$past(irq_in, 2)) & ~pending) == '0));

  // R10: gating lets no bit become newly pending
  p_gate_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !srst) |=> ((pending & ~$past(pending)) == '0));

  // R11: soft reset empties pending and clears itself
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ((pending == '0) && !srst));

  // R9: locked control register ignores non-secure writes
  p_lock_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ctrl_access && lock && !bus_secure && !srst) |=>
      (({gate, lock} == $past({gate, lock})) && !srst));
endmodule

bind secure_irq_router sirq_router_checker #(
  .NUM_SRC(NUM_SRC),
  .NUM_CPU(NUM_CPU),
  .ADDR_W (ADDR_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .pending   (pend_q),
  .gate      (gate_q),
  .srst      (srst_q),
  .lock      (lock_q),
  .bus_we    (bus_we),
  .bus_secure(bus_secure),
  .bus_addr  (bus_addr)
);

// File: tb/secure_irq_router_bench.sv
module secure_irq_router_bench;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          we;
  logic          sec;
  logic [31:0]   rdata;
  logic [NS-1:0] irq_in;
  logic [NC-1:0] irq_o;
  logic [NC-1:0] fiq_o;

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  secure_irq_router u_secure_irq_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_we    (we),
    .bus_secure(sec),
    .bus_rdata (rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_o),
    .fiq_out   (fiq_o)
  );

  // Behavioural reference model
  logic [15:0] m_route [NS];
  logic [31:0] m_pend;
  logic [31:0] m_prev;
  logic        m_gate, m_sr, m_lock;

  function automatic logic [31:0] m_owned();
    logic [31:0] r = '0;
    for (int i = 0; i < NS; i++)
      r[i] = m_route[i][0] | m_route[i][4] | m_route[i][8] | m_route[i][12];
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a, logic s);
    int blk = int'(a[AW-1:4]);
    int off = int'(a[3:0]);
    if (!(off == 0 || off == 4 || off == 8)) return 32'h0;
    if (blk == 0) return {24'h0, m_gate, m_sr, m_lock, 5'h0};
    if (blk == 1) return s ? m_pend : (m_pend & ~m_owned());
    if (blk >= 2 && blk < 2 + NS) return {16'h0, m_route[blk-2]};
    return 32'h0;
  endfunction

  function automatic logic [NC-1:0] m_out(bit want_fast);
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && (m_route[i][c*4+2 +: 2] != 2'd0) && (m_route[i][c*4+1] == want_fast))
          r[c] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_route[i] = '0;
      m_pend = '0; m_prev = '0;
      m_gate = 0; m_sr = 0; m_lock = 0;
    end else begin
      logic [31:0] edges, clr;
      logic [2:0]  cv, nv;
      logic        ng, ns, nl;
      int blk, off;
      edges = irq_in & ~m_prev;
      blk = int'(addr[AW-1:4]);
      off = int'(addr[3:0]);
      clr = '0;
      ng = m_gate; nl = m_lock; ns = 1'b0;
      if (we && (off == 0 || off == 4 || off == 8)) begin
        if (blk == 1 && off == 8) clr = wdata & (sec ? 32'hFFFF_FFFF : ~m_owned());
        if (blk >= 2 && blk < 2 + NS && !m_sr) begin
          for (int c = 0; c < NC; c++) begin
            logic [3:0] o, w;
            o = m_route[blk-2][c*4 +: 4];
            w = wdata[c*4 +: 4];
            if (!(o[0] && !sec))
              m_route[blk-2][c*4 +: 4] = (off == 0) ? w : (off == 4) ? (o | w) : (o & ~w);
          end
        end
        if (blk == 0 && (!m_lock || sec)) begin
          cv = {m_gate, m_sr, m_lock};
          nv = (off == 0) ? wdata[7:5] : (off == 4) ? (cv | wdata[7:5]) : (cv & ~wdata[7:5]);
          ng = nv[2]; nl = nv[0]; ns = m_sr ? 1'b0 : nv[1];
        end
      end
      if (m_sr) begin
        for (int i = 0; i < NS; i++) m_route[i] = '0;
        m_pend = '0;
      end else begin
        m_pend = (m_pend & ~clr) | (m_gate ? 32'h0 : edges);
      end
      m_prev = irq_in;
      m_gate = ng; m_lock = nl; m_sr = ns;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, "irq_out vs model", {28'h0, irq_o}, {28'h0, m_out(1'b0)});
      check(tag, "fiq_out vs model", {28'h0, fiq_o}, {28'h0, m_out(1'b1)});
      check(tag, "rdata vs model", rdata, m_read(addr, sec));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic s);
    @(negedge clk); #1;
    addr = a; wdata = d; we = 1'b1; sec = s;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic s, logic [31:0] exp, string req);
    @(negedge clk); #1;
    addr = a; sec = s; we = 1'b0;
    @(negedge clk); #2;
    check(req, "register read", rdata, exp);
  endtask

  task automatic pin(int i, bit v);
    @(negedge clk); #1;
    irq_in[i] = v;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; sec = 1'b0; irq_in = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    tag = "R1";
    settle();
    check("R1", "irq_out after reset", {28'h0, irq_o}, 32'h0);
    check("R1", "fiq_out after reset", {28'h0, fiq_o}, 32'h0);
    rd(12'h010, 1'b1, 32'h0, "R1");
    rd(12'h020, 1'b1, 32'h0, "R1");
    rd(12'h000, 1'b1, 32'h0, "R1");

    tag = "R4";
    wr(12'h050, 32'h0000_00E8, 1'b1);
    rd(12'h050, 1'b1, 32'h0000_00E8, "R4");
    wr(12'h054, 32'h0000_0400, 1'b1);
    rd(12'h058, 1'b0, 32'h0000_04E8, "R4");
    wr(12'h058, 32'h0000_0400, 1'b1);
    rd(12'h054, 1'b1, 32'h0000_00E8, "R4");

    tag = "R2";
    pin(3, 1'b1);
    settle();
    check("R3", "irq_out routed src3", {28'h0, irq_o}, 32'h1);
    check("R3", "fiq_out routed src3", {28'h0, fiq_o}, 32'h2);
    rd(12'h010, 1'b1, 32'h8, "R2");

    tag = "R5";
    wr(12'h010, 32'hFFFF_FFFF, 1'b1);
    wr(12'h014, 32'hFFFF_FFFF, 1'b1);
    rd(12'h010, 1'b1, 32'h8, "R5");
    wr(12'h018, 32'h8, 1'b1);
    rd(12'h010, 1'b1, 32'h0, "R5");
    settle();
    check("R2", "held level not recaptured", {28'h0, irq_o}, 32'h0);

    tag = "R6";
    pin(3, 1'b0);
    @(negedge clk); #1;
    irq_in[3] = 1'b1; addr = 12'h018; wdata = 32'h8; we = 1'b1; sec = 1'b1;
    @(negedge clk); #1;
    we = 1'b0;
    rd(12'h010, 1'b1, 32'h8, "R6");
    check("R6", "edge beats clear on irq_out", {28'h0, irq_o}, 32'h1);
    wr(12'h018, 32'h8, 1'b1);

    tag = "R3";
    wr(12'h070, 32'h0000_0200, 1'b1);
    pin(5, 1'b1);
    settle();
    check("R3", "masked level gives no fiq", {28'h0, fiq_o}, 32'h0);
    rd(12'h010, 1'b1, 32'h20, "R3");
    wr(12'h018, 32'h20, 1'b1);
    pin(5, 1'b0);

    tag = "R7";
    wr(12'h090, 32'h0000_0009, 1'b1);
    pin(7, 1'b1);
    settle();
    check("R7", "secure source still routed", {28'h0, irq_o}, 32'h1);
    rd(12'h010, 1'b1, 32'h80, "R7");
    rd(12'h010, 1'b0, 32'h0, "R7");
    wr(12'h018, 32'h80, 1'b0);
    rd(12'h010, 1'b1, 32'h80, "R7");

    tag = "R8";
    wr(12'h090, 32'h0000_0080, 1'b0);
    rd(12'h090, 1'b1, 32'h89, "R8");
    wr(12'h098, 32'h0000_000F, 1'b0);
    rd(12'h090, 1'b0, 32'h89, "R8");
    wr(12'h098, 32'h0000_0001, 1'b1);
    rd(12'h090, 1'b1, 32'h88, "R8");
    rd(12'h010, 1'b0, 32'h80, "R7");
    wr(12'h018, 32'h80, 1'b0);
    rd(12'h010, 1'b1, 32'h0, "R7");
    pin(7, 1'b0);

    tag = "R9";
    wr(12'h004, 32'h20, 1'b0);
    rd(12'h000, 1'b0, 32'h20, "R9");
    wr(12'h004, 32'h80, 1'b0);
    rd(12'h000, 1'b0, 32'h20, "R9");
    wr(12'h004, 32'h80, 1'b1);
    rd(12'h008, 1'b0, 32'hA0, "R9");

    tag = "R10";
    pin(3, 1'b0);
    pin(3, 1'b1);
    settle();
    rd(12'h010, 1'b1, 32'h0, "R10");
    check("R10", "gated edge lost", {28'h0, irq_o}, 32'h0);
    wr(12'h008, 32'h80, 1'b1);
    rd(12'h000, 1'b1, 32'h20, "R9");
    pin(3, 1'b0);
    pin(3, 1'b1);
    settle();
    rd(12'h010, 1'b1, 32'h8, "R2");
    wr(12'h004, 32'h80, 1'b1);
    rd(12'h010, 1'b1, 32'h8, "R10");
    check("R10", "gating keeps irq_out", {28'h0, irq_o}, 32'h1);
    check("R10", "gating keeps fiq_out", {28'h0, fiq_o}, 32'h2);
    wr(12'h008, 32'h80, 1'b1);

    tag = "R11";
    wr(12'h004, 32'h40, 1'b1);
    rd(12'h000, 1'b1, 32'h20, "R11");
    rd(12'h050, 1'b1, 32'h0, "R11");
    rd(12'h010, 1'b1, 32'h0, "R11");
    check("R11", "outputs after soft reset", {28'h0, irq_o | fiq_o}, 32'h0);

    tag = "R12";
    wr(12'h00C, 32'hFF, 1'b1);
    rd(12'h00C, 1'b1, 32'h0, "R12");
    rd(12'h000, 1'b1, 32'h20, "R12");
    wr(12'h400, 32'hFFFF, 1'b1);
    rd(12'h400, 1'b1, 32'h0, "R12");
    rd(12'h022, 1'b1, 32'h0, "R12");

    wr(12'h008, 32'h20, 1'b1);
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      int k;
      @(negedge clk); #1;
      k = $urandom_range(0, 9);
      case (k)
        0, 1:    addr = AW'(4 * $urandom_range(0, 2));
        2, 3:    addr = AW'(12'h010 + 4 * $urandom_range(0, 2));
        9:       addr = AW'($urandom_range(12'h230, 12'hFFF));
        default: addr = AW'(12'h020 + 16 * $urandom_range(0, NS-1) + 4 * $urandom_range(0, 2));
      endcase
      wdata = $urandom;
      if (k < 2 && $urandom_range(0, 7) != 0) wdata[6] = 1'b0;
      we  = ($urandom_range(0, 2) == 0);
      sec = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 1) != 0) irq_in[$urandom_range(0, NS-1)] ^= 1'b1;
    end
    @(negedge clk); #1;
    we = 1'b0;
    settle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule